// File: doc/BRIEF.md
# Lockstep Sensor Sync Timing Generator

This block owns the video timing of an image sensor. From a clock shared by every camera node it counts pixels and lines and drives horizontal sync, vertical sync and an active-video flag into the sensor. Nodes that run on the same clock and are aligned once stay in lockstep from then on. With the default parameters a frame has 640x480 visible pixels, scanned progressively. The totals are 800 clocks per line and 525 lines per frame, which gives 30 frames per second at a 12.6 MHz pixel clock.

The counters can be realigned in two ways: by a command pulse from the host's register logic, or by a trigger pulse from the parent node. On the node chosen as root, a start request from the host does not go out at once. It is held as pending until the frame reaches a programmable line, and is then sent as a trigger pulse one line long. Child nodes receive that pulse on their trigger input, so every node begins on the same frame. All pins are plain level or pulse control signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `sensor_sync_gen`

## Requirements
- R1: The position runs through H_TOTAL pixel clocks per line and V_TOTAL lines per frame, then wraps to pixel 0 of line 0. The first cycle after reset is pixel 0 of line 0.
- R2: `active` is 1 exactly when pixel < H_ACT and line < V_ACT. During reset it shows position (0,0), so it is 1.
- R3: `hsync` is 1 for pixels H_ACT+H_FP up to H_ACT+H_FP+H_SW-1 of every line. `vsync` is 1 for every clock of lines V_ACT+V_FP up to V_ACT+V_FP+V_SW-1. Both are 0 during reset.
- R4: If `resync_cmd` or `trig_in` is 1 at a clock edge, the next cycle is pixel 0 of line 0, and timing continues from there.
- R5: `frame_start` is 1 for exactly one cycle whenever the position becomes pixel 0 of line 0, either by the wrap of R1 or by R4. It is 0 during reset and in the first cycle after reset.
- R6: With `is_root`=1, a `start_req` pulse sets `start_pending`. `start_pending` clears at the same edge where `trig_out` rises.
- R7: `trig_out` rises one clock after a cycle in which `start_pending` is 1 and the position is pixel 0 of line `release_line`. It then stays 1 for exactly H_TOTAL cycles.
- R8: With `is_root`=0, `start_req` is ignored: `start_pending` and `trig_out` stay 0.
- R9: A `start_req` that arrives in the release cycle itself, while nothing is pending, does not fire. It fires at `release_line` of the following frame.
- R10: During reset `trig_out`, `start_pending` and `frame_start` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| is_root | input | 1 | Node acts as root and issues the trigger |
| resync_cmd | input | 1 | Host command pulse that realigns the counters |
| trig_in | input | 1 | Trigger from the parent node, realigns the counters |
| start_req | input | 1 | Host start request pulse (root only) |
| release_line | input | LW | Line on which a pending start is released |
| hsync | output | 1 | Horizontal sync to the sensor, active high |
| vsync | output | 1 | Vertical sync to the sensor, active high |
| active | output | 1 | Visible pixel region |
| frame_start | output | 1 | One-cycle strobe on the first pixel of a frame |
| trig_out | output | 1 | One-line trigger pulse to the child nodes |
| start_pending | output | 1 | A start request is waiting for the release line |

## Verification
Two pairs of functions can coincide. The first pair is a realignment and the natural frame wrap: the bench pulses `trig_in` exactly on the last pixel of a frame and expects a single `frame_start` and an unbroken restart from (0,0). The second pair is a new start request and the release point: the bench raises `start_req` in the very cycle the position is pixel 0 of `release_line` with nothing pending, and requires the trigger one whole frame later rather than at once. A reference model that tracks position, pending state and the trigger window compares every output on every cycle. A queue of expected release lines is checked against the position seen at each rise of `trig_out`.

// File: rtl/sync_pkg.sv
package sync_pkg;
  function automatic int unsigned width_for(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/sync_counter.sv
module sync_counter #(
  parameter int unsigned H_TOTAL = 800,
  parameter int unsigned V_TOTAL = 525,
  localparam int unsigned PW = sync_pkg::width_for(H_TOTAL),
  localparam int unsigned LW = sync_pkg::width_for(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  output logic [PW-1:0] pix,
  output logic [LW-1:0] line,
  output logic          frame_start
);
  localparam logic [PW-1:0] PIX_LAST  = PW'(H_TOTAL - 1);
  localparam logic [LW-1:0] LINE_LAST = LW'(V_TOTAL - 1);

  logic end_of_line, end_of_frame;
  assign end_of_line  = (pix == PIX_LAST);
  assign end_of_frame = end_of_line && (line == LINE_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix         <= '0;
      line        <= '0;
      frame_start <= 1'b0;
    end else begin
      frame_start <= clear || end_of_frame;
      if (clear || end_of_line) pix <= '0;
      else                      pix <= pix + 1'b1;
      if (clear || end_of_frame) line <= '0;
      else if (end_of_line)      line <= line + 1'b1;
    end
  end

  // R4: a realignment lands on the origin on the next cycle
  a_r4_clear_origin: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (pix == '0) && (line == '0));
  // R1: the position stays in range
  a_r1_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (pix <= PIX_LAST) && (line <= LINE_LAST));
  // R5: the strobe only marks the origin
  a_r5_strobe_origin: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (pix == '0) && (line == '0));
endmodule

// File: rtl/sync_decode.sv
module sync_decode #(
  parameter int unsigned H_ACT = 640,
  parameter int unsigned H_FP  = 16,
  parameter int unsigned H_SW  = 96,
  parameter int unsigned V_ACT = 480,
  parameter int unsigned V_FP  = 10,
  parameter int unsigned V_SW  = 2,
  parameter int unsigned PW    = 10,
  parameter int unsigned LW    = 10
) (
  input  logic          rst_n,
  input  logic [PW-1:0] pix,
  input  logic [LW-1:0] line,
  output logic          hsync,
  output logic          vsync,
  output logic          active
);
  localparam logic [PW-1:0] HS_BEG = PW'(H_ACT + H_FP);
  localparam logic [PW-1:0] HS_END = PW'(H_ACT + H_FP + H_SW);
  localparam logic [LW-1:0] VS_BEG = LW'(V_ACT + V_FP);
  localparam logic [LW-1:0] VS_END = LW'(V_ACT + V_FP + V_SW);
  localparam logic [PW-1:0] H_VIS  = PW'(H_ACT);
  localparam logic [LW-1:0] V_VIS  = LW'(V_ACT);

  always_comb begin
    active = (pix < H_VIS) && (line < V_VIS);
    hsync  = rst_n && (pix >= HS_BEG) && (pix < HS_END);
    vsync  = rst_n && (line >= VS_BEG) && (line < VS_END);
  end
endmodule

// File: rtl/root_trigger.sv
module root_trigger #(
  parameter int unsigned H_TOTAL = 800,
  parameter int unsigned PW      = 10,
  parameter int unsigned LW      = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          is_root,
  input  logic          start_req,
  input  logic [LW-1:0] release_line,
  input  logic [PW-1:0] pix,
  input  logic [LW-1:0] line,
  output logic          trig_out,
  output logic          start_pending
);
  logic [PW-1:0] remain;
  logic          fire;

  assign fire = start_pending && (pix == '0) && (line == release_line);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_pending <= 1'b0;
      trig_out      <= 1'b0;
      remain        <= '0;
    end else begin
      if (fire)                      start_pending <= 1'b0;
      else if (is_root && start_req) start_pending <= 1'b1;

      if (fire) begin
        trig_out <= 1'b1;
        remain   <= PW'(H_TOTAL - 1);
      end else if (trig_out) begin
        if (remain == '0) trig_out <= 1'b0;
        else              remain   <= remain - 1'b1;
      end
    end
  end

  // R6: the trigger rise consumes the pending request
  a_r6_rise_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_out) |-> !start_pending && $past(start_pending));
  // R7: the trigger rises only one clock after the release position
  a_r7_rise_at_line: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_out) |-> ($past(pix) == '0) && ($past(line) == $past(release_line)));
  // R8: a non-root node never raises pending from idle
  a_r8_nonroot_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_root && !start_pending) |=> !start_pending);
endmodule

// File: rtl/sensor_sync_gen.sv
module sensor_sync_gen #(
  parameter int unsigned H_ACT = 640,
  parameter int unsigned H_FP  = 16,
  parameter int unsigned H_SW  = 96,
  parameter int unsigned H_BP  = 48,
  parameter int unsigned V_ACT = 480,
  parameter int unsigned V_FP  = 10,
  parameter int unsigned V_SW  = 2,
  parameter int unsigned V_BP  = 33,
  localparam int unsigned H_TOTAL = H_ACT + H_FP + H_SW + H_BP,
  localparam int unsigned V_TOTAL = V_ACT + V_FP + V_SW + V_BP,
  localparam int unsigned PW = sync_pkg::width_for(H_TOTAL),
  localparam int unsigned LW = sync_pkg::width_for(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          is_root,
  input  logic          resync_cmd,
  input  logic          trig_in,
  input  logic          start_req,
  input  logic [LW-1:0] release_line,
  output logic          hsync,
  output logic          vsync,
  output logic          active,
  output logic          frame_start,
  output logic          trig_out,
  output logic          start_pending
);
  logic [PW-1:0] pix;
  logic [LW-1:0] line;
  logic          realign;

  assign realign = resync_cmd || trig_in;

  sync_counter #(.H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(realign),
    .pix(pix), .line(line), .frame_start(frame_start)
  );

  sync_decode #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SW(H_SW),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SW(V_SW),
    .PW(PW), .LW(LW)
  ) u_dec (
    .rst_n(rst_n), .pix(pix), .line(line),
    .hsync(hsync), .vsync(vsync), .active(active)
  );

  root_trigger #(.H_TOTAL(H_TOTAL), .PW(PW), .LW(LW)) u_root (
    .clk(clk), .rst_n(rst_n), .is_root(is_root), .start_req(start_req),
    .release_line(release_line), .pix(pix), .line(line),
    .trig_out(trig_out), .start_pending(start_pending)
  );

  // R5: the frame strobe is a single cycle unless a realignment repeats it
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !realign) |=> !frame_start);
  // R2: the first pixel of a frame is visible
  a_r2_origin_visible: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> active && !vsync && !hsync);
  // R3: horizontal sync never overlaps visible pixels
  a_r3_hs_blank: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |-> !active);
endmodule

// File: tb/sensor_sync_gen_bench.sv
module sensor_sync_gen_bench;
  localparam int HA = 8, HF = 2, HS = 3, HB = 3;
  localparam int VA = 6, VF = 1, VS = 2, VB = 1;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int LW = $clog2(VT);

  logic clk = 0, rst_n = 0;
  logic is_root = 0, resync_cmd = 0, trig_in = 0, start_req = 0;
  logic [LW-1:0] release_line = '0;
  logic hsync, vsync, active, frame_start, trig_out, start_pending;

  int total = 0, bad = 0;
  int mp = 0, ml = 0, mtrem = 0;
  logic mfs = 0, mpend = 0, mtrig = 0;
  int rel_q[$];
  logic prev_trig = 0;
  int hi_len = 0;

  always #4 clk = ~clk;

  sensor_sync_gen #(.H_ACT(HA), .H_FP(HF), .H_SW(HS), .H_BP(HB),
                    .V_ACT(VA), .V_FP(VF), .V_SW(VS), .V_BP(VB)) u_sensor_sync_gen (
    .clk(clk), .rst_n(rst_n), .is_root(is_root), .resync_cmd(resync_cmd),
    .trig_in(trig_in), .start_req(start_req), .release_line(release_line),
    .hsync(hsync), .vsync(vsync), .active(active), .frame_start(frame_start),
    .trig_out(trig_out), .start_pending(start_pending));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model from the requirements
  always @(posedge clk) begin
    if (!rst_n) begin
      mp <= 0; ml <= 0; mfs <= 0; mpend <= 0; mtrig <= 0; mtrem <= 0;
    end else begin
      logic fire;
      fire = mpend && mp == 0 && ml == int'(release_line);
      mfs <= resync_cmd || trig_in || (mp == HT-1 && ml == VT-1);
      if (resync_cmd || trig_in) begin mp <= 0; ml <= 0; end
      else if (mp == HT-1) begin mp <= 0; ml <= (ml == VT-1) ? 0 : ml + 1; end
      else mp <= mp + 1;
      if (fire) mpend <= 0; else if (is_root && start_req) mpend <= 1;
      if (fire) begin mtrig <= 1; mtrem <= HT-1; end
      else if (mtrig) begin
        if (mtrem == 0) mtrig <= 0; else mtrem <= mtrem - 1;
      end
    end
  end

  // monitor: compares every cycle, away from the active edge
  always @(negedge clk) begin
    logic ea, eh, ev;
    ea = (mp < HA) && (ml < VA);
    eh = rst_n && (mp >= HA+HF) && (mp < HA+HF+HS);
    ev = rst_n && (ml >= VA+VF) && (ml < VA+VF+VS);
    check("R1/R2 active", active, ea);
    check("R3 hsync", hsync, eh);
    check("R3 vsync", vsync, ev);
    check("R5/R10 frame_start", frame_start, mfs);
    check("R6/R10 start_pending", start_pending, mpend);
    check("R7/R8 trig_out", trig_out, mtrig);
    if (trig_out && !prev_trig) begin
      if (rel_q.size() == 0) check("R7 unexpected trigger", 1, 0);
      else begin
        int r;
        r = rel_q.pop_front();
        check("R7 rise line", ml, r);
        check("R7 rise pixel", mp, 1);
      end
      hi_len = 0;
    end
    if (trig_out) hi_len++;
    if (!trig_out && prev_trig) check("R7 pulse length", hi_len, HT);
    prev_trig = trig_out;
  end

  task automatic go_to(input int p, input int l);
    while (!(mp == p && ml == l)) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1; @(negedge clk); s = 0;
  endtask

  task automatic request_start(input int rel);
    release_line = LW'(rel);
    rel_q.push_back(rel);
    pulse(start_req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 trig during reset", trig_out, 0);
    check("R10 pending during reset", start_pending, 0);
    rst_n = 1;
    // R1 R2 R3 R5: two full frames of free run
    repeat (2*HT*VT + 5) @(negedge clk);
    // R4: host command mid-frame
    go_to(5, 3); pulse(resync_cmd);
    repeat (HT*VT) @(negedge clk);
    // R4 R5: trigger input exactly on the last pixel of a frame
    go_to(HT-1, VT-1); pulse(trig_in);
    repeat (HT*2) @(negedge clk);
    // R6 R7: root release at line 3
    is_root = 1;
    go_to(4, 0); request_start(3);
    check("R6 pending set", start_pending, 1);
    repeat (HT*VT) @(negedge clk);
    // R9: request in the release cycle with nothing pending
    go_to(0, 5); release_line = LW'(5);
    rel_q.push_back(5); pulse(start_req);
    check("R9 pending after late request", start_pending, 1);
    repeat (HT*VT + HT*7) @(negedge clk);
    // R7: release on line 0
    go_to(3, 2); request_start(0);
    repeat (HT*VT*2) @(negedge clk);
    // R8: non-root ignores requests
    is_root = 0;
    go_to(0, 1); release_line = LW'(2); pulse(start_req);
    check("R8 no pending on non-root", start_pending, 0);
    repeat (HT*VT) @(negedge clk);
    check("R8 no trigger on non-root", trig_out, 0);
    check("R7 all triggers seen", rel_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule